// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes two-channel serial audio from a sender and hands parallel left and right 16-bit samples to a converter core. Three input formats are supported. Two of them share one data line, with a channel-select line that names which channel each bit belongs to; one of these carries offset binary and the other two's complement. The third format carries left and right on two separate data lines, clocked together, and a separate load pulse marks the end of each word pair.

The bit clock, channel-select/load line and data lines come from outside the block and are not related to the system clock. All four lines are synchronized on a system clock that runs at least four times faster than the bit clock. Bit and select values are taken on each rising bit-clock edge that is seen after synchronization. Both outputs are always offset binary. A new left/right pair appears with a single-cycle strobe.

Top module: `serial_audio_rx`

## Requirements
- R1: While rst_ni is low, left_o and right_o are zero and sample_vld_o is low.
- R2: mode_i is captured in the first system clock after reset is released: 2'b00 = shared line with offset binary, 2'b01 = shared line with two's complement, 2'b10 and 2'b11 = dual line. Later changes on mode_i have no effect until the next reset.
- R3: In the shared-line formats, the bits arrive most significant first on dat_a_i. The value of sel_i taken on the same rising edge of bck_i sets the channel of each bit: 0 is left and 1 is right.
- R4: In the shared-line formats, on the first rising bck_i edge at which sel_i is taken as 0 after it was taken as 1, the block outputs the left and right words that are complete at that point, with a strobe. That bit then starts the next left word.
- R5: In the two's-complement format, bit 15 of both output words is inverted, so that the outputs are offset binary. Bits 14..0 pass through unchanged.
- R6: In the dual-line format, dat_a_i (left) and dat_b_i (right) are shifted in on the same bck_i rising edges, most significant bit first. A rising edge of sel_i moves both words to the outputs with a strobe and starts a fresh word on both channels.
- R7: A word that ends with fewer than 16 bits is left-justified, and its missing low bits are zero.
- R8: Bits after the 16th bit of a word are ignored.
- R9: sample_vld_o is high for exactly one system cycle per transfer. left_o and right_o change only in a cycle where sample_vld_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Input format select, taken after reset |
| bck_i | input | 1 | Serial bit clock |
| sel_i | input | 1 | Channel select (shared line) or load pulse (dual line) |
| dat_a_i | input | 1 | Shared data line, or left data in dual-line format |
| dat_b_i | input | 1 | Right data in dual-line format |
| left_o | output | 16 | Left sample, offset binary |
| right_o | output | 16 | Right sample, offset binary |
| sample_vld_o | output | 1 | One-cycle strobe when both outputs update |

## Verification
The bench drives runs of random words against a bench model, and adds directed cases at the boundaries. Short words check the zero fill; a design that shifted short words right, or kept stale low bits, would return wrong values. Words longer than 16 bits check that extra bits are dropped; a design that kept shifting would lose the most significant bits. The values 0x8000 and 0x7FFF in two's-complement mode check the sign flip, which a missing or misplaced inversion would corrupt. A mode change without a reset checks that the captured mode is kept; a receiver that followed mode_i live would stop strobing or decode the dual-line stream as shared-line data.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    MODE_SHR_OB = 2'b00,
    MODE_SHR_TC = 2'b01,
    MODE_DUAL_A = 2'b10,
    MODE_DUAL_B = 2'b11
  } rx_mode_e;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign q_o    = s2_q;
  assign rise_o = s2_q & ~s3_q;
endmodule

// File: rtl/sar_word.sv
module sar_word #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              start_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  localparam logic [WORD_W-1:0] PTR_TOP  = {1'b1, {(WORD_W-1){1'b0}}};
  localparam logic [WORD_W-1:0] PTR_NEXT = PTR_TOP >> 1;

  logic [WORD_W-1:0] sh_q, ptr_q;

  // ptr_q marks the next bit slot; zero once the word is full
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      ptr_q <= PTR_TOP;
    end else if (clear_i) begin
      sh_q  <= '0;
      ptr_q <= PTR_TOP;
    end else if (start_i) begin
      sh_q  <= {bit_i, {(WORD_W-1){1'b0}}};
      ptr_q <= PTR_NEXT;
    end else if (shift_i) begin
      if (bit_i) sh_q <= sh_q | ptr_q;
      ptr_q <= ptr_q >> 1;
    end
  end

  assign word_o = sh_q;
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sar_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              bck_i,
  input  logic              sel_i,
  input  logic              dat_a_i,
  input  logic              dat_b_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              sample_vld_o
);
  localparam int NCH   = 2;
  localparam int SYN_W = 4;

  rx_mode_e mode_q;
  logic     mode_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_SHR_OB;
      mode_vld_q <= 1'b0;
    end else if (!mode_vld_q) begin
      mode_q     <= rx_mode_e'(mode_i);
      mode_vld_q <= 1'b1;
    end
  end

  logic [SYN_W-1:0] syn_q, syn_rise;

  sar_sync #(.W(SYN_W)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({dat_b_i, dat_a_i, sel_i, bck_i}),
    .q_o    (syn_q),
    .rise_o (syn_rise)
  );

  logic bck_rise, fr_rise, sel_s, da_s, db_s;
  assign bck_rise = syn_rise[0];
  assign fr_rise  = syn_rise[1];
  assign sel_s    = syn_q[1];
  assign da_s     = syn_q[2];
  assign db_s     = syn_q[3];

  logic is_dual, is_tc;
  assign is_dual = mode_q[1];
  assign is_tc   = (mode_q == MODE_SHR_TC);

  // select value seen at the previous bit-clock edge
  logic sel_prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sel_prev_q <= 1'b0;
    else if (bck_rise) sel_prev_q <= sel_s;
  end

  logic to_left, to_right, load;
  assign to_left  = !is_dual && bck_rise && !sel_s &&  sel_prev_q;
  assign to_right = !is_dual && bck_rise &&  sel_s && !sel_prev_q;
  assign load     = is_dual ? fr_rise : to_left;

  logic [NCH-1:0][WORD_W-1:0] word;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic ch_sel, ch_bit;
    assign ch_sel = (ch == 0) ? !sel_s : sel_s;
    assign ch_bit = (ch == 0) ? da_s : (is_dual ? db_s : da_s);

    sar_word #(.WORD_W(WORD_W)) u_word (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (is_dual && fr_rise),
      .start_i ((ch == 0) ? to_left : to_right),
      .shift_i (bck_rise && (is_dual || ch_sel)),
      .bit_i   (ch_bit),
      .word_o  (word[ch])
    );
  end

  function automatic logic [WORD_W-1:0] to_ob(input logic [WORD_W-1:0] w, input logic flip);
    return {w[WORD_W-1] ^ flip, w[WORD_W-2:0]};
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_o       <= '0;
      right_o      <= '0;
      sample_vld_o <= 1'b0;
    end else begin
      sample_vld_o <= load;
      if (load) begin
        left_o  <= to_ob(word[0], is_tc);
        right_o <= to_ob(word[1], is_tc);
      end
    end
  end
endmodule

// File: rtl/sar_checker.sv
module sar_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sample_vld_o,
  input logic [WORD_W-1:0] left_o,
  input logic [WORD_W-1:0] right_o,
  input logic [1:0]        mode_q,
  input logic              mode_vld_q,
  input logic              bck_rise,
  input logic              fr_rise
);
  AST_VLD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_vld_o |=> !sample_vld_o); // R9

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_vld_o |-> ($stable(left_o) && $stable(right_o))); // R9

  AST_MODE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_vld_q && $past(mode_vld_q)) |-> $stable(mode_q)); // R2

  AST_LOAD_FROM_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_vld_o |-> $past(bck_rise || fr_rise)); // R4

  AST_DUAL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_vld_q && mode_q[1] && sample_vld_o) |-> $past(fr_rise)); // R6
endmodule

bind serial_audio_rx sar_checker #(.WORD_W(WORD_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sample_vld_o (sample_vld_o),
  .left_o       (left_o),
  .right_o      (right_o),
  .mode_q       (mode_q),
  .mode_vld_q   (mode_vld_q),
  .bck_rise     (bck_rise),
  .fr_rise      (fr_rise)
);

// File: tb/serial_audio_rx_tb_top.sv
module serial_audio_rx_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic        bck_i = 1'b0;
  logic        sel_i = 1'b0;
  logic        dat_a_i = 1'b0;
  logic        dat_b_i = 1'b0;
  logic [15:0] left_o, right_o;
  logic        sample_vld_o;

  always #2.5 clk_i = ~clk_i;

  serial_audio_rx dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .bck_i(bck_i),
    .sel_i(sel_i), .dat_a_i(dat_a_i), .dat_b_i(dat_b_i),
    .left_o(left_o), .right_o(right_o), .sample_vld_o(sample_vld_o)
  );

  int    n_chk = 0, n_fail = 0, n_vld = 0, n_exp = 0;
  int    r9_bad = 0;
  bit    done = 0;
  string cur_tag = "R4";

  // bench model
  logic [1:0]  m_mode;
  logic        m_prev;
  logic [15:0] m_w [2];
  int          m_c [2];
  logic [31:0] exq [$];

  function automatic logic [15:0] ob(input logic [15:0] w);
    return (m_mode == 2'b01) ? {~w[15], w[14:0]} : w;
  endfunction

  task automatic m_clr(input int ch);
    m_w[ch] = '0; m_c[ch] = 0;
  endtask

  task automatic m_add(input int ch, input logic b);
    if (m_c[ch] < 16) m_w[ch][15 - m_c[ch]] = b;
    m_c[ch]++;
  endtask

  task automatic m_push();
    exq.push_back({ob(m_w[0]), ob(m_w[1])});
    n_exp++;
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor away from the active edge
  logic        prev_vld = 0;
  logic [31:0] prev_out = '0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (sample_vld_o) begin
        n_vld++;
        if (prev_vld) r9_bad++;
        if (exq.size() == 0) check(cur_tag, {left_o, right_o}, 32'hxxxx_xxxx);
        else check(cur_tag, {left_o, right_o}, exq.pop_front());
      end else if ({left_o, right_o} !== prev_out) r9_bad++;
      prev_vld = sample_vld_o;
      prev_out = {left_o, right_o};
    end
  end

  task automatic bit_low_to_high();
    repeat (4) @(negedge clk_i);
    bck_i = 1'b1;
    repeat (4) @(negedge clk_i);
    bck_i = 1'b0;
  endtask

  task automatic send_shr(input logic s, input logic d);
    @(negedge clk_i);
    sel_i = s; dat_a_i = d; dat_b_i = $urandom_range(0, 1);
    if (!s && m_prev) begin m_push(); m_clr(0); m_add(0, d); end
    else if (s && !m_prev) begin m_clr(1); m_add(1, d); end
    else m_add(s ? 1 : 0, d);
    m_prev = s;
    bit_low_to_high();
  endtask

  task automatic shr_frame(input logic [15:0] l, input int nl, input logic [15:0] r, input int nr);
    for (int i = 0; i < nl; i++) send_shr(1'b0, (i < 16) ? l[15 - i] : 1'($urandom_range(0, 1)));
    for (int i = 0; i < nr; i++) send_shr(1'b1, (i < 16) ? r[15 - i] : 1'($urandom_range(0, 1)));
  endtask

  task automatic send_dual(input logic a, input logic b);
    @(negedge clk_i);
    dat_a_i = a; dat_b_i = b;
    m_add(0, a); m_add(1, b);
    bit_low_to_high();
  endtask

  task automatic dual_word(input logic [15:0] l, input logic [15:0] r, input int n);
    for (int i = 0; i < n; i++)
      send_dual((i < 16) ? l[15 - i] : 1'($urandom_range(0, 1)),
                (i < 16) ? r[15 - i] : 1'($urandom_range(0, 1)));
    repeat (4) @(negedge clk_i);
    sel_i = 1'b1;
    m_push(); m_clr(0); m_clr(1);
    repeat (4) @(negedge clk_i);
    sel_i = 1'b0;
  endtask

  task automatic drain();
    repeat (12) @(negedge clk_i);
    check({cur_tag, " pending"}, 32'(exq.size()), 32'd0);
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk_i);
    rst_ni = 1'b0; mode_i = m; bck_i = 0; sel_i = 0; dat_a_i = 0; dat_b_i = 0;
    repeat (3) @(negedge clk_i);
    check("R1 reset outputs", {left_o, right_o}, 32'd0);
    check("R1 reset strobe", {31'd0, sample_vld_o}, 32'd0);
    m_mode = m; m_prev = 0; m_clr(0); m_clr(1); exq.delete();
    prev_vld = 0; prev_out = '0;
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned seed = $urandom(32'd1541);
    seed = seed;

    // shared line, offset binary
    do_reset(2'b00);
    cur_tag = "R3";
    shr_frame(16'h1234, 16, 16'hABCD, 16);
    shr_frame(16'hF00F, 16, 16'h0001, 16);
    send_shr(1'b0, 1'b0);
    drain();
    cur_tag = "R4";
    for (int k = 0; k < 20; k++) shr_frame(16'($urandom), 16, 16'($urandom), 16);
    send_shr(1'b0, 1'b1);
    drain();
    cur_tag = "R7";
    shr_frame(16'hFFFF, 12, 16'hFFFF, 9);
    shr_frame(16'hA5A5, 1, 16'h5A5A, 15);
    send_shr(1'b0, 1'b0);
    drain();
    cur_tag = "R8";
    for (int k = 0; k < 6; k++) shr_frame(16'($urandom), 17 + k, 16'($urandom), 24 - k);
    send_shr(1'b0, 1'b0);
    drain();

    // shared line, two's complement
    do_reset(2'b01);
    cur_tag = "R5";
    shr_frame(16'h8000, 16, 16'h7FFF, 16);
    shr_frame(16'h0000, 16, 16'hFFFF, 16);
    for (int k = 0; k < 12; k++)
      shr_frame(16'($urandom), 10 + (k % 10), 16'($urandom), 16);
    send_shr(1'b0, 1'b0);
    drain();

    // dual line
    do_reset(2'b10);
    cur_tag = "R6";
    dual_word(16'hC3C3, 16'h3C3C, 16);
    for (int k = 0; k < 15; k++) dual_word(16'($urandom), 16'($urandom), 16);
    drain();
    cur_tag = "R7";
    dual_word(16'hFFFF, 16'hFFFF, 5);
    cur_tag = "R8";
    dual_word(16'h1357, 16'h2468, 21);
    drain();
    cur_tag = "R2";
    mode_i = 2'b00;
    for (int k = 0; k < 6; k++) dual_word(16'($urandom), 16'($urandom), 16);
    drain();

    do_reset(2'b11);
    cur_tag = "R6";
    for (int k = 0; k < 8; k++) dual_word(16'($urandom), 16'($urandom), 8 + k);
    drain();

    check("R4 strobe count", 32'(n_vld), 32'(n_exp));
    check("R9 strobe width/output hold", 32'(r9_bad), 32'd0);
    finish_run();
  end
endmodule